// File: doc/BRIEF.md
# Branch Direction Predictor Miss Profiler

This block replays a trace of resolved conditional branches through a small direction predictor and counts how often that predictor would have guessed wrong. Each trace event supplies the address of a branch instruction and the direction the branch actually went. Two address bits just above the word offset select one of four slots. Each slot holds a two-bit state value. The state of the selected slot gives a guess for the direction. If the guess differs from the real outcome, a miss counter is bumped. The slot state is then updated.

Two update rules can be chosen for each event. The first is a saturating up/down counter that needs two wrong guesses in a row before the guess flips. The second is a single-bit rule in which the slot simply adopts the last outcome it failed to predict. Running the same trace under both rules and comparing the final miss counts shows the value of the hysteresis. The guess for the current address is visible on an output at all times, so the trace source can also log per-event predictions.

Top module: `branch_miss_profiler`

## Requirements
- R1: After a synchronous active-high reset, every slot holds state value 1, so every address predicts not taken, and the miss count reads zero.
- R2: The slot is selected by event address bits [3:2] only. Addresses that differ in any other bit share a slot and influence each other.
- R3: `pred_taken` is 1 exactly when the selected slot's state value is 2 or 3.
- R4: With `rule_two_bit` = 1, a taken outcome raises the slot state by one up to a ceiling of 3, and a not-taken outcome lowers it by one down to a floor of 0.
- R5: With `rule_two_bit` = 0, a correctly predicted event leaves the slot unchanged. A mispredicted event sets it to 3 when the outcome was taken and to 0 when it was not taken, so the very next event on that slot predicts the last outcome.
- R6: A valid event whose outcome differs from `pred_taken` raises `miss_count` by exactly one on the following cycle. A correctly predicted event leaves it unchanged.
- R7: `miss_count` is MISS_W bits wide (32 by default) and holds at all ones rather than wrapping.
- R8: `pred_taken` follows `ev_addr` combinationally and, during a valid event, shows the guess made before that event's update. The update is visible from the next cycle.
- R9: While `ev_valid` is 0, `ev_taken` and `rule_two_bit` change neither any slot nor the miss count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | A resolved branch event is present this cycle |
| ev_addr | input | ADDR_W | Address of the branch instruction |
| ev_taken | input | 1 | Resolved outcome: 1 taken, 0 not taken |
| rule_two_bit | input | 1 | Update rule for this event: 1 saturating counter, 0 single-bit |
| pred_taken | output | 1 | Predicted direction for the slot selected by `ev_addr` |
| miss_count | output | MISS_W | Number of mispredicted events since reset, saturating |

## Verification
The hardest state to reach is a saturated miss count, because it takes 2^MISS_W − 1 mispredictions. The bench therefore builds the block with a narrow counter. It then feeds one slot a long run of alternating outcomes under the single-bit rule, which makes every event a miss, and continues past the ceiling to show the count holds. Aliasing between addresses and the hysteresis of the two-bit rule are brought about by directed sequences on colliding addresses. A fixed-seed random stream that switches rules between events also covers states in which a slot trained under one rule is updated under the other.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

    localparam int CTR_W = 2;

    typedef logic [CTR_W-1:0] ctr_t;

    localparam ctr_t CTR_INIT = ctr_t'(1);
    localparam ctr_t CTR_MAX  = '1;
    localparam ctr_t CTR_MIN  = '0;

    typedef enum logic {
        RULE_ONE_BIT = 1'b0,
        RULE_TWO_BIT = 1'b1
    } rule_e;

    typedef struct packed {
        logic  en;
        logic  taken;
        rule_e rule;
    } upd_t;

    function automatic logic ctr_predict(input ctr_t c);
        return c[CTR_W-1];
    endfunction

    function automatic ctr_t ctr_next(input ctr_t c, input logic taken, input rule_e rule);
        ctr_t n;
        n = c;
        if (rule == RULE_TWO_BIT) begin
            if (taken && c != CTR_MAX)
                n = c + ctr_t'(1);
            else if (!taken && c != CTR_MIN)
                n = c - ctr_t'(1);
        end else begin
            if (ctr_predict(c) != taken)
                n = taken ? CTR_MAX : CTR_MIN;
        end
        return n;
    endfunction

endpackage

// File: rtl/bpred_slot_table.sv
module bpred_slot_table
    import bpred_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] sel_idx,
    input  upd_t             upd,
    output ctr_t             sel_ctr
);

    ctr_t slot_vec [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        ctr_t q;
        logic hit;

        assign hit = upd.en && (sel_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst)
                q <= CTR_INIT;
            else if (hit)
                q <= ctr_next(q, upd.taken, upd.rule);
        end

        assign slot_vec[g] = q;
    end

    assign sel_ctr = slot_vec[sel_idx];

endmodule

// File: rtl/bpred_miss_counter.sv
module bpred_miss_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bump,
    output logic [W-1:0] count
);

    logic at_top;
    assign at_top = &count;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (bump && !at_top)
            count <= count + W'(1);
    end

endmodule

// File: rtl/branch_miss_profiler.sv
module branch_miss_profiler
    import bpred_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SLOTS   = 4,
    parameter int IDX_LSB = 2,
    parameter int MISS_W  = 32,
    localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              ev_taken,
    input  logic              rule_two_bit,
    output logic              pred_taken,
    output logic [MISS_W-1:0] miss_count
);

    logic [IDX_W-1:0] slot_idx;
    ctr_t             slot_ctr;
    upd_t             upd;
    logic             mispredict;
    logic             addr_unused;

    assign slot_idx    = ev_addr[IDX_LSB +: IDX_W];
    assign addr_unused = ^{ev_addr[ADDR_W-1:IDX_LSB+IDX_W], ev_addr[IDX_LSB-1:0]};

    assign upd.en    = ev_valid;
    assign upd.taken = ev_taken;
    assign upd.rule  = rule_e'(rule_two_bit);

    bpred_slot_table #(
        .SLOTS(SLOTS)
    ) u_table (
        .clk     (clk),
        .rst     (rst),
        .sel_idx (slot_idx),
        .upd     (upd),
        .sel_ctr (slot_ctr)
    );

    assign pred_taken = ctr_predict(slot_ctr);
    assign mispredict = ev_valid && (pred_taken != ev_taken);

    bpred_miss_counter #(
        .W(MISS_W)
    ) u_miss (
        .clk   (clk),
        .rst   (rst),
        .bump  (mispredict),
        .count (miss_count)
    );

endmodule

// File: rtl/bpred_checker.sv
module bpred_checker #(
    parameter int MISS_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ev_valid,
    input logic              ev_taken,
    input logic              pred_taken,
    input logic [MISS_W-1:0] miss_count
);

    // R6
    miss_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && pred_taken != ev_taken && !(&miss_count))
        |=> (miss_count == $past(miss_count) + MISS_W'(1)));

    // R6
    hit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && pred_taken == ev_taken) |=> $stable(miss_count));

    // R7
    miss_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (&miss_count) |=> (&miss_count));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ev_valid |=> $stable(miss_count));

endmodule

bind branch_miss_profiler bpred_checker #(
    .MISS_W(MISS_W)
) u_bpred_chk (
    .clk        (clk),
    .rst        (rst),
    .ev_valid   (ev_valid),
    .ev_taken   (ev_taken),
    .pred_taken (pred_taken),
    .miss_count (miss_count)
);

// File: tb/test_branch_miss_profiler.sv
module test_branch_miss_profiler;

    localparam int ADDR_W = 32;
    localparam int MISS_W = 12;
    localparam int MAXM   = (1 << MISS_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ev_valid = 1'b0;
    logic [ADDR_W-1:0] ev_addr = '0;
    logic              ev_taken = 1'b0;
    logic              rule_two_bit = 1'b1;
    logic              pred_taken;
    logic [MISS_W-1:0] miss_count;

    int checks = 0;
    int failures = 0;
    int model [4];
    int exp_miss = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    branch_miss_profiler #(
        .ADDR_W (ADDR_W),
        .MISS_W (MISS_W)
    ) i_branch_miss_profiler (
        .clk          (clk),
        .rst          (rst),
        .ev_valid     (ev_valid),
        .ev_addr      (ev_addr),
        .ev_taken     (ev_taken),
        .rule_two_bit (rule_two_bit),
        .pred_taken   (pred_taken),
        .miss_count   (miss_count)
    );

    function automatic int m_next(input int c, input bit t, input bit two);
        if (two) return t ? ((c < 3) ? c + 1 : 3) : ((c > 0) ? c - 1 : 0);
        if ((c >= 2) != t) return t ? 3 : 0;
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) model[i] = 1;
        exp_miss = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ev_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        check(miss_count == 0, "R1 miss count after reset", int'(miss_count), 0);
        for (int i = 0; i < 4; i++) begin
            ev_addr = ADDR_W'(i * 4 + 32'h100);
            #1;
            check(pred_taken == 1'b0, "R1 slot predicts not taken", int'(pred_taken), 0);
        end
    endtask

    task automatic send(input logic [ADDR_W-1:0] a, input bit t, input bit two, input string req);
        int  idx;
        bit  exp_p;
        @(negedge clk);
        ev_valid = 1'b1;
        ev_addr = a;
        ev_taken = t;
        rule_two_bit = two;
        #1;
        idx = int'(a[3:2]);
        exp_p = (model[idx] >= 2);
        check(pred_taken == exp_p, {req, " R3 R8 prediction"}, int'(pred_taken), int'(exp_p));
        if (exp_p != t && exp_miss != MAXM) exp_miss++;
        model[idx] = m_next(model[idx], t, two);
        @(posedge clk);
        #1;
        ev_valid = 1'b0;
        check(int'(miss_count) == exp_miss, {req, " R6 miss count"}, int'(miss_count), exp_miss);
    endtask

    task automatic peek(input logic [ADDR_W-1:0] a, input string req);
        int idx;
        ev_addr = a;
        #1;
        idx = int'(a[3:2]);
        check(pred_taken == (model[idx] >= 2), req, int'(pred_taken), int'(model[idx] >= 2));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);
        model_reset();
        repeat (3) @(negedge clk);
        do_reset();

        // R4 hysteresis on slot 0: 1 -> 2 (miss), 3 (hit), 2 (miss), 3 (hit), 3 saturated
        send(32'h0000_0000, 1'b1, 1'b1, "R4 inc");
        send(32'h0000_0000, 1'b1, 1'b1, "R4 inc");
        send(32'h0000_0000, 1'b0, 1'b1, "R4 dec");
        send(32'h0000_0000, 1'b1, 1'b1, "R4 inc");
        send(32'h0000_0000, 1'b1, 1'b1, "R4 ceiling");
        send(32'h0000_0000, 1'b1, 1'b1, "R4 ceiling");
        // R2 aliasing: 0x10 and 0xABC0 share slot 0, while 0x4 (slot 1) is untouched
        peek(32'h0000_0010, "R2 alias sees trained slot");
        peek(32'h0000_ABC1, "R2 alias with low bits sees trained slot");
        peek(32'h0000_0004, "R2 other slot untouched");
        send(32'h0000_0010, 1'b0, 1'b1, "R2 alias dec");
        send(32'h0000_ABC0, 1'b0, 1'b1, "R2 alias dec");
        send(32'h0000_0000, 1'b0, 1'b1, "R4 floor");
        send(32'h0000_0000, 1'b0, 1'b1, "R4 floor");
        send(32'h0000_0000, 1'b1, 1'b1, "R4 leaves floor");

        // R5 single-bit rule on slot 2
        send(32'h0000_0008, 1'b1, 1'b0, "R5 miss sets taken");
        send(32'h0000_0008, 1'b1, 1'b0, "R5 hit no change");
        send(32'h0000_0008, 1'b0, 1'b0, "R5 miss sets not taken");
        send(32'h0000_0008, 1'b1, 1'b0, "R5 flips immediately");

        // R9 idle cycles with toggling outcome do nothing
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            ev_valid = 1'b0;
            ev_addr = 32'h0000_0008;
            ev_taken = k[0];
            rule_two_bit = k[1];
        end
        #1;
        check(int'(miss_count) == exp_miss, "R9 idle miss count", int'(miss_count), exp_miss);
        peek(32'h0000_0008, "R9 idle slot unchanged");
        send(32'h0000_0008, 1'b0, 1'b1, "R9 slot state after idle");

        // random stream with mixed rules and biased outcomes
        for (int n = 0; n < 2000; n++) begin
            logic [ADDR_W-1:0] a;
            bit t;
            a = ADDR_W'($urandom);
            t = (a[3:2] == 2'd3) ? ($urandom_range(0, 9) < 8) : bit'($urandom_range(0, 1));
            send(a, t, bit'($urandom_range(0, 3) != 0), "rand");
        end

        // R1 synchronous reset mid-run
        do_reset();

        // R7 saturation: alternating outcomes under single-bit rule miss every time
        for (int n = 0; n < MAXM + 20; n++)
            send(32'h0000_000C, bit'(n % 2 == 0), 1'b0, "R7 saturate");
        check(int'(miss_count) == MAXM, "R7 held at all ones", int'(miss_count), MAXM);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule